// File: doc/BRIEF.md
# Run-Length Unsigned Magnitude Comparator

This block compares two unsigned operands of the same parameterised width and raises exactly one of three flags: the first operand is larger, the second operand is larger, or the two are equal. It is purely combinational, so the flags follow the operands with no clock and no latency. It is meant to sit inside a datapath where a single-cycle ordering decision is needed. Examples are a sort network, a bound check or a max/min select.

The decision does not come from locating and isolating the top differing bit. The block first marks, bit by bit, where each operand holds a 1 that the other lacks. Each of these two direction vectors then becomes a mask whose ones cover only the positions strictly above the vector's highest set bit. A vector with no set bit gives a mask of all ones. The larger operand is the one whose mask has the shorter run of ones. A bitwise cross term between the two masks, followed by an OR reduction, shows which mask that is. When both cross terms are empty the operands are equal. The masks are built with a logarithmic suffix-OR network rather than a bit-serial scan.

Top module: `rl_mag_cmp`

## Requirements
- R1: `gt` is 1 exactly when `a` is greater than `b`, both read as unsigned binary with bit W-1 as the most significant bit.
- R2: `lt` is 1 exactly when `a` is less than `b` under the same unsigned reading.
- R3: `eq` is 1 exactly when every bit of `a` matches the bit of `b` at the same position.
- R4: For every operand pair exactly one of `gt`, `lt`, `eq` is 1.
- R5: An all-zero operand against an all-ones operand orders the all-ones operand as larger, whichever side it is on. Two all-zero operands, or two all-ones operands, give `eq`.
- R6: When the operands differ only in bit W-1, the operand with a 1 in bit W-1 is reported larger, whatever the lower bits hold.
- R7: When the operands differ only in bit 0, the operand with a 1 in bit 0 is reported larger.
- R8: The flags are a combinational function of the operands. They are valid in the same clock cycle the operands are applied, with no register and no reset.
- R9: R1 to R4 hold for any width W of 1 or more. They are checked at W = 8 over all operand pairs and at the default W = 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First unsigned operand |
| b | input | W | Second unsigned operand |
| gt | output | 1 | High when a is greater than b |
| lt | output | 1 | High when a is less than b |
| eq | output | 1 | High when a equals b |

## Verification
Every flag is due in the same cycle its operands are applied, because no register lies between the ports. The bench therefore drives new operands just after a rising clock edge and reads all three flags at the following falling edge. By that point the combinational network has settled, and the next operand change is still half a period away. One 8-bit instance is swept through all 65,536 operand pairs. Alongside it, a 16-bit instance receives seeded random pairs and the directed corner pairs, so the width parameter is exercised at two sizes in every cycle.

// File: rtl/rl_cmp_pkg.sv
// Package rl_cmp_pkg
// Shared types for the run-length magnitude comparator.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package rl_cmp_pkg;

    // Result of one comparison; exactly one member is expected high.
    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_flags_t;

endpackage

// File: rtl/rl_cmp_dirvec.sv
// Module rl_cmp_dirvec
// Forms the two direction vectors: bit i of wins_a is set when a holds a 1
// at position i and b holds a 0; wins_b is the mirror case.
// Assumes equal-width unsigned operands.
module rl_cmp_dirvec #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] wins_a,
    output logic [W-1:0] wins_b
);

    // Per-bit ownership of a lone 1.
    always_comb begin
        wins_a = a & ~b;
        wins_b = ~a & b;
    end

endmodule

// File: rtl/rl_cmp_runmask.sv
// Module rl_cmp_runmask
// Turns a vector into a mask with ones strictly above its top set bit and
// zeros at and below it; an all-zero vector gives an all-ones mask.
// Implemented as a log2(W)-level parallel suffix-OR (bit i ORs all bits >= i),
// then inverted. Assumes W >= 1.
module rl_cmp_runmask #(
    parameter int W = 16
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] mask
);

    localparam int LEVELS = (W > 1) ? $clog2(W) : 0;

    logic [W-1:0] lvl [0:LEVELS];

    // Level zero is the raw vector.
    always_comb lvl[0] = vec;

    genvar s, i;
    generate
        for (s = 0; s < LEVELS; s++) begin : g_level
            localparam int SPAN = 1 << s;
            for (i = 0; i < W; i++) begin : g_bit
                if (i + SPAN < W) begin : g_merge
                    // Fold in the partial OR from SPAN positions higher.
                    always_comb lvl[s+1][i] = lvl[s][i] | lvl[s][i+SPAN];
                end else begin : g_pass
                    // Nothing higher to fold at this span.
                    always_comb lvl[s+1][i] = lvl[s][i];
                end
            end
        end
    endgenerate

    // A position is in the run when no set bit lies at or above it.
    always_comb mask = ~lvl[LEVELS];

endmodule

// File: rtl/rl_cmp_decide.sv
// Module rl_cmp_decide
// Cross-compares the two run masks and reduces to the three flags.
// The larger operand owns the shorter run of ones, so (~mask_a & mask_b)
// is nonzero for a > b and (mask_a & ~mask_b) is nonzero for a < b.
// Assumes masks are prefix runs of ones from the MSB down.
module rl_cmp_decide
    import rl_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] mask_a,
    input  logic [W-1:0] mask_b,
    output cmp_flags_t   flags
);

    logic [W-1:0] cross_gt;
    logic [W-1:0] cross_lt;

    // Cross terms between the masks.
    always_comb begin
        cross_gt = ~mask_a & mask_b;
        cross_lt = mask_a & ~mask_b;
    end

    // OR reductions and equality when both sides are empty.
    always_comb begin
        flags.gt = |cross_gt;
        flags.lt = |cross_lt;
        flags.eq = ~(flags.gt | flags.lt);
    end

endmodule

// File: rtl/rl_mag_cmp.sv
// Module rl_mag_cmp
// Combinational unsigned magnitude comparator built from direction vectors,
// run masks and a cross-term reduction. No clock, no reset; flags follow the
// operands directly. Assumes W >= 1.
module rl_mag_cmp
    import rl_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         gt,
    output logic         lt,
    output logic         eq
);

    logic [W-1:0] wins_a;
    logic [W-1:0] wins_b;
    logic [W-1:0] mask_a;
    logic [W-1:0] mask_b;
    cmp_flags_t   flags;

    rl_cmp_dirvec #(.W(W)) u_dirvec (
        .a      (a),
        .b      (b),
        .wins_a (wins_a),
        .wins_b (wins_b)
    );

    rl_cmp_runmask #(.W(W)) u_mask_a (
        .vec  (wins_a),
        .mask (mask_a)
    );

    rl_cmp_runmask #(.W(W)) u_mask_b (
        .vec  (wins_b),
        .mask (mask_b)
    );

    rl_cmp_decide #(.W(W)) u_decide (
        .mask_a (mask_a),
        .mask_b (mask_b),
        .flags  (flags)
    );

    // Drive the ports from the flag struct.
    always_comb begin
        gt = flags.gt;
        lt = flags.lt;
        eq = flags.eq;
    end

endmodule

// File: rtl/rl_mag_cmp_chk.sv
// Module rl_mag_cmp_chk
// Assertion checker bound to rl_mag_cmp. The block is combinational, so the
// checks are immediate assertions evaluated whenever the operands settle.
module rl_mag_cmp_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         gt,
    input logic         lt,
    input logic         eq,
    input logic [W-1:0] wins_a,
    input logic [W-1:0] wins_b,
    input logic [W-1:0] mask_a,
    input logic [W-1:0] mask_b
);

    // Flag behaviour against the language's unsigned relations.
    always_comb begin
        a_r1_gt_order: assert (gt == (a > b))
            else $error("R1: gt=%b for a=%h b=%h", gt, a, b);
        a_r2_lt_order: assert (lt == (a < b))
            else $error("R2: lt=%b for a=%h b=%h", lt, a, b);
        a_r3_eq_match: assert (eq == (a == b))
            else $error("R3: eq=%b for a=%h b=%h", eq, a, b);
        a_r4_one_flag: assert ($countones({gt, lt, eq}) == 1)
            else $error("R4: flags %b%b%b", gt, lt, eq);
        if (wins_a == '0 && wins_b == '0) begin
            a_r3_full_masks: assert (mask_a == '1 && mask_b == '1 && eq)
                else $error("R3: equal operands gave masks %h %h", mask_a, mask_b);
        end
    end

endmodule

bind rl_mag_cmp rl_mag_cmp_chk #(.W(W)) u_chk (
    .a      (a),
    .b      (b),
    .gt     (gt),
    .lt     (lt),
    .eq     (eq),
    .wins_a (wins_a),
    .wins_b (wins_b),
    .mask_a (mask_a),
    .mask_b (mask_b)
);

// File: tb/test_rl_mag_cmp.sv
// Bench for rl_mag_cmp: exhaustive 8-bit sweep, seeded random 16-bit pairs
// and directed corners, compared against expected flags computed here.
module test_rl_mag_cmp;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [15:0] a16 = '0, b16 = '0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic gt16, lt16, eq16, gt8, lt8, eq8;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rl_mag_cmp #(.W(16)) i_rl_mag_cmp (
        .a (a16), .b (b16), .gt (gt16), .lt (lt16), .eq (eq16)
    );

    rl_mag_cmp #(.W(8)) i_rl_mag_cmp_w8 (
        .a (a8), .b (b8), .gt (gt8), .lt (lt8), .eq (eq8)
    );

    // Expected flags {gt, lt, eq} from the requirements.
    function automatic logic [2:0] expect_flags(input logic [15:0] x, input logic [15:0] y);
        return {x > y, x < y, x == y};
    endfunction

    task automatic check(input string tag, input int w, input logic [15:0] x,
                         input logic [15:0] y, input logic g, input logic l, input logic e);
        logic [2:0] ex;
        ex = expect_flags(x, y);
        checks++;
        if (g !== ex[2]) begin
            errors++;
            $display("FAIL R1 %s w=%0d a=%h b=%h: gt=%b expected %b", tag, w, x, y, g, ex[2]);
        end
        if (l !== ex[1]) begin
            errors++;
            $display("FAIL R2 %s w=%0d a=%h b=%h: lt=%b expected %b", tag, w, x, y, l, ex[1]);
        end
        if (e !== ex[0]) begin
            errors++;
            $display("FAIL R3 %s w=%0d a=%h b=%h: eq=%b expected %b", tag, w, x, y, e, ex[0]);
        end
        if ($countones({g, l, e}) != 1) begin
            errors++;
            $display("FAIL R4 %s w=%0d a=%h b=%h: flags=%b%b%b expected one hot", tag, w, x, y, g, l, e);
        end
    endtask

    // R8: drive after a rising edge, sample at the next falling edge.
    task automatic apply(input string tag, input logic [15:0] x16, input logic [15:0] y16,
                         input logic [7:0] x8, input logic [7:0] y8);
        @(posedge clk);
        a16 = x16; b16 = y16; a8 = x8; b8 = y8;
        @(negedge clk);
        check(tag, 16, a16, b16, gt16, lt16, eq16);
        check(tag, 8, {8'h00, a8}, {8'h00, b8}, gt8, lt8, eq8);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_c0de;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R3 R8: operands at zero from time zero give equality.
        @(negedge clk);
        check("R8 initial", 16, a16, b16, gt16, lt16, eq16);
        check("R8 initial", 8, {8'h00, a8}, {8'h00, b8}, gt8, lt8, eq8);
        // R5: all-zero and all-ones corners.
        apply("R5 zero-ones", 16'h0000, 16'hFFFF, 8'h00, 8'hFF);
        apply("R5 ones-zero", 16'hFFFF, 16'h0000, 8'hFF, 8'h00);
        apply("R5 ones-ones", 16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF);
        apply("R5 zero-zero", 16'h0000, 16'h0000, 8'h00, 8'h00);
        // R6: difference only in the MSB.
        apply("R6 msb a", 16'h8123, 16'h0123, 8'h81, 8'h01);
        apply("R6 msb b", 16'h7FFF, 16'hFFFF, 8'h7F, 8'hFF);
        // R7: difference only in the LSB.
        apply("R7 lsb a", 16'hA5A5, 16'hA5A4, 8'h5B, 8'h5A);
        apply("R7 lsb b", 16'h0000, 16'h0001, 8'hFE, 8'hFF);
        // R3: equal non-trivial operands.
        apply("R3 equal", 16'h3C96, 16'h3C96, 8'h96, 8'h96);
        // R9: exhaustive 8-bit sweep, random 16-bit pairs in parallel.
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            apply("R9 sweep", r, (i % 7 == 0) ? r : 16'($urandom),
                  8'(i >> 8), 8'(i));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog: run still active, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule